// File: doc/BRIEF.md
# System Control Port with Refresh Indicator

This block is a byte-wide control and status port. It sits next to a programmable interval timer. Software writes a byte to it to set two control bits. The first bit gates timer channel 2. The second bit enables the speaker data path. The block drives the channel 2 gate pin from the first bit. It drives the speaker pin with the channel 2 output level, masked by the second bit.

A read of the port returns a status byte. The byte holds both stored control bits, the live channel 2 output level, and a refresh indicator. The refresh indicator is a free-running flag that flips once every refresh interval, which is about 15.085 µs. The interval comes from a clock divider, and its length in system clocks is a parameter. The default of 3771 cycles suits a 250 MHz clock. Four status positions normally carry parity and NMI flags; here they always read as zero.

Top module: `sysctl_port`

## Requirements
- R1: When `wrStrobe` is high at a clock edge, bit 0 of `wrData` is stored as the gate bit. `ch2Gate` shows the stored value from the next cycle on, and `rdData[0]` reads it back.
- R2: When `wrStrobe` is high at a clock edge, bit 1 of `wrData` is stored as the speaker enable. `rdData[1]` reads it back from the next cycle on.
- R3: `spkOut` is high exactly when `ch2Out` is high and the stored speaker enable is set, with no clock delay.
- R4: `rdData[5]` equals the present level of `ch2Out` in the same cycle.
- R5: `rdData[2]`, `rdData[3]`, `rdData[6]` and `rdData[7]` always read as zero.
- R6: `rdData[4]` flips once every `REFRESH_DIV` clock cycles. The first flip comes `REFRESH_DIV` edges after reset is released. Writes do not affect it.
- R7: While `rstN` is low, the gate bit, the speaker enable, the refresh flag and the divider are all cleared. The clear is asynchronous.
- R8: Bits 7 to 2 of a written byte are ignored. The status byte after such a write depends only on bits 1 and 0 of the write.
- R9: Without `wrStrobe`, the stored gate and speaker bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | Write enable for the control byte |
| wrData | input | 8 | Control byte written to the port |
| ch2Out | input | 1 | Output level of timer channel 2 |
| rdData | output | 8 | Status byte (combinational) |
| ch2Gate | output | 1 | Gate drive for timer channel 2 |
| spkOut | output | 1 | Speaker drive: channel 2 output masked by the enable |

## Verification
The assertions run on every cycle and cover three behaviours:
- The stored control bits change only on a write strobe, and after a strobe they take the written bits.
- The refresh flag flips exactly on the divider strobe and holds at all other times.
- The divider stays within its range and strobes at most once in a row.

Other behaviours are shown only by the bench scenarios, which compare the outputs against a behavioural model on every cycle:
- The period and phase of the refresh flag after reset.
- The zero reserved positions.
- The combinational mirroring of `ch2Out` into the status byte and the speaker pin.
- The masking of the upper written bits.
- A reset applied in the middle of a run.

// File: rtl/sysctl_port_pkg.sv
package sysctl_port_pkg;
  localparam int PORT_W      = 8;
  localparam int GATE_BIT    = 0;
  localparam int SPK_BIT     = 1;
  localparam int REFRESH_BIT = 4;
  localparam int OUT_BIT     = 5;
  localparam int CTL_W       = 2;

  typedef struct packed {
    logic loadCtl;      // capture the control bits this edge
    logic flipRefresh;  // refresh interval elapsed this edge
  } ctlStrobe_t;
endpackage

// File: rtl/sysctl_port_ctl.sv
module sysctl_port_ctl
  import sysctl_port_pkg::*;
#(
  parameter int REFRESH_DIV = 3771
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStrobe,
  output ctlStrobe_t strobes
);
  localparam int CNT_W = $clog2(REFRESH_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             divWrap;

  assign divWrap = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (divWrap) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strobes.loadCtl     = wrStrobe;
    strobes.flipRefresh = divWrap;
  end

  // The divider never runs past its last count (R6).
  assert_div_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= LAST);

  // After a wrap the divider restarts, so no two strobes come back to back (R6).
  generate
    if (REFRESH_DIV > 1) begin : g_gap
      assert_refresh_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
        strobes.flipRefresh |=> !strobes.flipRefresh);
    end
  endgenerate
endmodule

// File: rtl/sysctl_port_dp.sv
module sysctl_port_dp
  import sysctl_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [CTL_W-1:0]  wrBits,
  input  logic              ch2Out,
  output logic [PORT_W-1:0] rdData,
  output logic              ch2Gate,
  output logic              spkOut
);
  logic gateQ;
  logic spkEnQ;
  logic refreshQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ  <= 1'b0;
      spkEnQ <= 1'b0;
    end else if (strobes.loadCtl) begin
      gateQ  <= wrBits[0];
      spkEnQ <= wrBits[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    refreshQ <= 1'b0;
    else if (strobes.flipRefresh) refreshQ <= ~refreshQ;
  end

  always_comb begin
    rdData              = '0;
    rdData[GATE_BIT]    = gateQ;
    rdData[SPK_BIT]     = spkEnQ;
    rdData[REFRESH_BIT] = refreshQ;
    rdData[OUT_BIT]     = ch2Out;
  end

  assign ch2Gate = gateQ;
  assign spkOut  = ch2Out & spkEnQ;

  // A strobed write lands both control bits (R1, R2).
  assert_gate_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCtl |=> gateQ == $past(wrBits[0]));
  assert_spk_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCtl |=> spkEnQ == $past(wrBits[1]));

  // Without a write the control bits hold (R9).
  assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCtl |=> $stable(gateQ) && $stable(spkEnQ));

  // The refresh flag flips on the strobe and holds at all other times (R6).
  assert_refresh_flip_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flipRefresh |=> refreshQ != $past(refreshQ));
  assert_refresh_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flipRefresh |=> $stable(refreshQ));
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port
  import sysctl_port_pkg::*;
#(
  parameter int REFRESH_DIV = 3771
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [PORT_W-1:0] wrData,
  input  logic              ch2Out,
  output logic [PORT_W-1:0] rdData,
  output logic              ch2Gate,
  output logic              spkOut
);
  ctlStrobe_t       strobes;
  logic [CTL_W-1:0] wrBits;
  logic             unusedHighBits;

  // Only the two control positions are kept; the rest of the byte is dropped (R8).
  assign wrBits         = wrData[CTL_W-1:0];
  assign unusedHighBits = ^wrData[PORT_W-1:CTL_W];

  sysctl_port_ctl #(.REFRESH_DIV(REFRESH_DIV)) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .strobes  (strobes)
  );

  sysctl_port_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrBits  (wrBits),
    .ch2Out  (ch2Out),
    .rdData  (rdData),
    .ch2Gate (ch2Gate),
    .spkOut  (spkOut)
  );
endmodule

// File: tb/sysctl_port_tb.sv
module sysctl_port_tb_top;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic       ch2Out = 1'b0;
  logic [7:0] rdData;
  logic       ch2Gate;
  logic       spkOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit checking = 0;

  // Behavioural reference state
  int mGate = 0, mSpk = 0, mRefresh = 0, mEdges = 0;

  always #2 clk = ~clk; // 250 MHz

  sysctl_port #(.REFRESH_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrData(wrData),
    .ch2Out(ch2Out), .rdData(rdData), .ch2Gate(ch2Gate), .spkOut(spkOut)
  );

  // Model: R7 reset, R1/R2 load, R9 hold, R8 upper bits ignored, R6 refresh period
  always @(posedge clk) begin
    if (!rstN) begin
      mGate = 0; mSpk = 0; mRefresh = 0; mEdges = 0;
    end else begin
      if (wrStrobe) begin
        mGate = int'(wrData[0]);
        mSpk  = int'(wrData[1]);
      end
      mEdges = mEdges + 1;
      if (mEdges == DIV) begin
        mEdges = 0;
        mRefresh = 1 - mRefresh;
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      logic [7:0] expRd;
      bit bad;
      expRd = '0;
      expRd[0] = mGate[0];
      expRd[1] = mSpk[0];
      expRd[4] = mRefresh[0];
      expRd[5] = ch2Out;
      bad = 0;
      vectors++;
      if (rdData[0] !== expRd[0] || ch2Gate !== expRd[0]) begin
        bad = 1;
        $display("FAIL R1/R9 gate: rd=%b pin=%b exp=%b", rdData[0], ch2Gate, expRd[0]);
      end
      if (rdData[1] !== expRd[1]) begin
        bad = 1;
        $display("FAIL R2/R8 speaker enable: got %b exp %b", rdData[1], expRd[1]);
      end
      if (spkOut !== (ch2Out & mSpk[0])) begin
        bad = 1;
        $display("FAIL R3 spkOut: got %b exp %b", spkOut, ch2Out & mSpk[0]);
      end
      if (rdData[5] !== expRd[5]) begin
        bad = 1;
        $display("FAIL R4 out mirror: got %b exp %b", rdData[5], expRd[5]);
      end
      if ({rdData[7:6], rdData[3:2]} !== 4'b0) begin
        bad = 1;
        $display("FAIL R5 reserved bits: got %b exp 0000", {rdData[7:6], rdData[3:2]});
      end
      if (rdData[4] !== expRd[4]) begin
        bad = 1;
        $display("FAIL R6/R7 refresh: got %b exp %b", rdData[4], expRd[4]);
      end
      if (bad) fails++;
    end
  end

  task automatic step(input bit wr, input logic [7:0] d, input bit o);
    @(negedge clk); #1;
    wrStrobe = wr; wrData = d; ch2Out = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    checking = 1;
    // R7: reset state, then R6 free-running refresh
    repeat (4 * DIV) step(0, 8'h00, 0);
    // R1, R2, R3, R4 under several patterns
    step(1, 8'h01, 1); step(0, 8'h00, 1); step(0, 8'h00, 0);
    step(1, 8'h02, 1); step(0, 8'h00, 1); step(0, 8'h00, 0);
    step(1, 8'h03, 0); step(0, 8'h00, 1); step(0, 8'h00, 1);
    // R8: upper bits only, stored bits should become zero
    step(1, 8'hFC, 1); step(0, 8'h00, 1);
    step(1, 8'hFE, 1); step(0, 8'h00, 1);
    step(1, 8'hFD, 0); step(0, 8'h00, 1);
    // R6: back-to-back writes must not disturb refresh
    for (int i = 0; i < 3 * DIV; i++) step(1, 8'(i * 37 + 5), i[0]);
    // Pseudo-random mix
    begin
      logic [7:0] lfsr = 8'hA5;
      for (int i = 0; i < 200; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        step(lfsr[6], lfsr, lfsr[2]);
      end
    end
    // R7: mid-run reset with bits set
    step(1, 8'h03, 1);
    step(0, 8'h00, 1);
    @(negedge clk); #1 rstN = 1'b0;
    repeat (2) step(0, 8'h00, 1);
    @(negedge clk); #1 rstN = 1'b1;
    repeat (3 * DIV) step(0, 8'h00, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule